// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Write-Protection Traps

This block is a small fully associative translation buffer for a core that refills translations in software. Each slot maps a virtual page number to a physical frame number. Each slot also carries a valid flag and a modified flag; a set modified flag means the page may be written. Lookups enter on a valid/ready request channel and leave on a valid/ready response channel. A response gives either a frame number or a trap cause. Because a store never sets a modified bit silently, the handler can emulate one. A write that lands on a slot whose modified flag is clear traps with its own cause. The handler then records the page as dirty and upgrades the slot.

The handler drives a plain command port with one command per cycle, always accepted. A fill loads a slot, as read-only or as read-write. An upgrade makes a resident page writable. An invalidate drops a stale mapping. Per-frame dirty and used bits are exported as flat vectors. Each bit is the OR over every mapping that ever pointed at that frame.

Back-pressure rules: `req_ready` is high when no response is held or when the held one is being consumed in the same cycle. A response stays on `rsp_*`, unchanged, until `rsp_ready` is seen high with `rsp_valid`. While it is held, no new request is taken.

Top module: `soft_tlb`

## Requirements
- R1: After reset no response is pending, `req_ready` is high, every frame dirty and used bit is clear, and every lookup misses.
- R2: A lookup, read or write, that matches no valid slot returns cause 2'b01 (miss) with frame number 0.
- R3: A read that hits returns cause 2'b00 and the slot's frame number, whether or not the slot's modified flag is set.
- R4: A write that hits a slot with a clear modified flag returns cause 2'b10 with frame number 0. A write that hits a slot with the flag set returns cause 2'b00 and the frame number.
- R5: Command code 2'b01 (fill) loads the given page and frame into a slot with the valid flag set and the modified flag equal to `cmd_writable`. It marks the frame used, and also marks it dirty when `cmd_writable` is 1.
- R6: Command code 2'b10 (upgrade) sets the modified flag of the slot that holds `cmd_vpn` and marks that slot's frame dirty and used. If no slot holds the page, nothing changes.
- R7: Command code 2'b11 (invalidate) clears the slot that holds `cmd_vpn`, so later lookups of that page miss. If no slot holds the page, nothing changes. Code 2'b00 does nothing.
- R8: A fill of a page that is already resident rewrites that slot in place and leaves the replacement pointer where it is. A fill of any other page writes the slot named by a round-robin pointer. The pointer starts at slot 0, advances by one on each such fill and wraps after the last slot, whether or not the slot it names is valid.
- R9: The dirty and used bits of a frame are sticky until reset. A frame is dirty or used if any mapping to it ever made it so. A dirty frame is always also used.
- R10: A response appears in the cycle after its request is accepted. A lookup accepted in the same cycle as a command sees the table as it was before that command. A lookup accepted in any later cycle sees the command's effect.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response stays unchanged and `req_ready` is low. In the cycle the response is consumed, a new request may be accepted.
- R12: Cause code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request taken this cycle when valid |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_write | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_cause | output | 2 | 00 ok, 01 miss, 10 write to unmodified page |
| rsp_pfn | output | PFN_W | Frame number on success, 0 on a trap |
| cmd_valid | input | 1 | Handler command present |
| cmd_op | input | 2 | 00 none, 01 fill, 10 upgrade, 11 invalidate |
| cmd_vpn | input | VPN_W | Page the command acts on |
| cmd_pfn | input | PFN_W | Frame for a fill |
| cmd_writable | input | 1 | Fill loads the slot as read-write |
| frame_dirty | output | 2**PFN_W | Per-frame modified bookkeeping |
| frame_used | output | 2**PFN_W | Per-frame recently-used bookkeeping |

## Verification
A lookup and a handler command can take effect at the same clock edge. The bench provokes this in two ways. It issues a fill together with a read of the same page, which must miss. It also issues an upgrade together with a store to the same read-only page, which must still trap with cause 10. The bench then repeats each lookup on its own, one cycle later, and expects the new translation. This separates a table that is correctly sampled before the edge from one that forwards the command's effect or loses it.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
  typedef enum logic [1:0] {
    CAUSE_OK    = 2'b00,
    CAUSE_MISS  = 2'b01,
    CAUSE_WPROT = 2'b10
  } cause_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_FILL  = 2'b01,
    OP_UPGR  = 2'b10,
    OP_INVAL = 2'b11
  } op_e;
endpackage

// File: rtl/tlb_slot_array.sv
module tlb_slot_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 5,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_writable,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [VPN_W-1:0] cmd_vpn,
  input  logic [PFN_W-1:0] cmd_pfn,
  input  logic             cmd_writable,
  input  logic [IDX_W-1:0] victim_idx,
  output logic             cmd_hit,
  output logic [PFN_W-1:0] cmd_hit_pfn,
  output logic             take_victim
);
  import soft_tlb_pkg::*;

  logic [ENTRIES-1:0] slot_valid;
  logic [ENTRIES-1:0] slot_wr;
  logic [VPN_W-1:0]   slot_vpn [ENTRIES];
  logic [PFN_W-1:0]   slot_pfn [ENTRIES];
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] cm_match;
  logic [IDX_W-1:0]   cm_idx;
  logic [IDX_W-1:0]   fill_idx;
  logic               is_fill;

  assign is_fill = cmd_valid && (cmd_op == OP_FILL);

  always_comb begin
    lk_hit      = |lk_match;
    lk_pfn      = '0;
    lk_writable = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_pfn      = lk_pfn | slot_pfn[i];
        lk_writable = lk_writable | slot_wr[i];
      end
    end
  end

  always_comb begin
    cmd_hit     = |cm_match;
    cm_idx      = '0;
    cmd_hit_pfn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (cm_match[i]) begin
        cm_idx      = IDX_W'(i);
        cmd_hit_pfn = slot_pfn[i];
      end
    end
  end

  assign fill_idx    = cmd_hit ? cm_idx : victim_idx;
  assign take_victim = is_fill && !cmd_hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign lk_match[g] = slot_valid[g] && (slot_vpn[g] == lk_vpn);
    assign cm_match[g] = slot_valid[g] && (slot_vpn[g] == cmd_vpn);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_valid[g] <= 1'b0;
        slot_wr[g]    <= 1'b0;
        slot_vpn[g]   <= '0;
        slot_pfn[g]   <= '0;
      end else if (cmd_valid) begin
        unique case (cmd_op)
          OP_FILL: begin
            if (fill_idx == IDX_W'(g)) begin
              slot_valid[g] <= 1'b1;
              slot_wr[g]    <= cmd_writable;
              slot_vpn[g]   <= cmd_vpn;
              slot_pfn[g]   <= cmd_pfn;
            end
          end
          OP_UPGR: begin
            if (cm_match[g]) slot_wr[g] <= 1'b1;
          end
          OP_INVAL: begin
            if (cm_match[g]) slot_valid[g] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] victim_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       victim_idx <= '0;
    else if (advance) victim_idx <= (victim_idx == LAST) ? '0 : victim_idx + 1'b1;
  end
endmodule

// File: rtl/tlb_frame_book.sv
module tlb_frame_book #(
  parameter int PFN_W   = 5,
  localparam int FRAMES = 1 << PFN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark_en,
  input  logic [PFN_W-1:0]  mark_pfn,
  input  logic              mark_dirty,
  output logic [FRAMES-1:0] dirty,
  output logic [FRAMES-1:0] used
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty <= '0;
      used  <= '0;
    end else if (mark_en) begin
      used[mark_pfn] <= 1'b1;
      if (mark_dirty) dirty[mark_pfn] <= 1'b1;
    end
  end
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VPN_W-1:0]        req_vpn,
  input  logic                    req_write,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [1:0]              rsp_cause,
  output logic [PFN_W-1:0]        rsp_pfn,
  input  logic                    cmd_valid,
  input  logic [1:0]              cmd_op,
  input  logic [VPN_W-1:0]        cmd_vpn,
  input  logic [PFN_W-1:0]        cmd_pfn,
  input  logic                    cmd_writable,
  output logic [(1<<PFN_W)-1:0]   frame_dirty,
  output logic [(1<<PFN_W)-1:0]   frame_used
);
  import soft_tlb_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic             lk_hit, lk_writable;
  logic [PFN_W-1:0] lk_pfn;
  logic             cmd_hit, take_victim;
  logic [PFN_W-1:0] cmd_hit_pfn;
  logic [IDX_W-1:0] victim_idx;
  logic             accept;
  logic             mark_en, mark_dirty;
  logic [PFN_W-1:0] mark_pfn;

  tlb_slot_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_slots (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_vpn      (req_vpn),
    .lk_hit      (lk_hit),
    .lk_pfn      (lk_pfn),
    .lk_writable (lk_writable),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_vpn     (cmd_vpn),
    .cmd_pfn     (cmd_pfn),
    .cmd_writable(cmd_writable),
    .victim_idx  (victim_idx),
    .cmd_hit     (cmd_hit),
    .cmd_hit_pfn (cmd_hit_pfn),
    .take_victim (take_victim)
  );

  tlb_victim_ptr #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (take_victim),
    .victim_idx(victim_idx)
  );

  always_comb begin
    mark_en    = 1'b0;
    mark_pfn   = cmd_pfn;
    mark_dirty = cmd_writable;
    if (cmd_valid && cmd_op == OP_FILL) begin
      mark_en = 1'b1;
    end else if (cmd_valid && cmd_op == OP_UPGR && cmd_hit) begin
      mark_en    = 1'b1;
      mark_pfn   = cmd_hit_pfn;
      mark_dirty = 1'b1;
    end
  end

  tlb_frame_book #(.PFN_W(PFN_W)) u_book (
    .clk       (clk),
    .rst_n     (rst_n),
    .mark_en   (mark_en),
    .mark_pfn  (mark_pfn),
    .mark_dirty(mark_dirty),
    .dirty     (frame_dirty),
    .used      (frame_used)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_cause <= CAUSE_OK;
      rsp_pfn   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      if (!lk_hit) begin
        rsp_cause <= CAUSE_MISS;
        rsp_pfn   <= '0;
      end else if (req_write && !lk_writable) begin
        rsp_cause <= CAUSE_WPROT;
        rsp_pfn   <= '0;
      end else begin
        rsp_cause <= CAUSE_OK;
        rsp_pfn   <= lk_pfn;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk #(
  parameter int PFN_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [1:0]            rsp_cause,
  input logic [PFN_W-1:0]      rsp_pfn,
  input logic [(1<<PFN_W)-1:0] frame_dirty,
  input logic [(1<<PFN_W)-1:0] frame_used
);
  // R12
  cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_cause != 2'b11);

  // R2
  trap_pfn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause != 2'b00) |-> rsp_pfn == '0);

  // R11
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cause) && $stable(rsp_pfn)));

  // R10
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9
  dirty_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_dirty & ~frame_used) == '0);

  // R9
  sticky_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((frame_dirty & $past(frame_dirty)) == $past(frame_dirty)));

  // R9
  sticky_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((frame_used & $past(frame_used)) == $past(frame_used)));
endmodule

bind soft_tlb soft_tlb_chk #(.PFN_W(PFN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_cause  (rsp_cause),
  .rsp_pfn    (rsp_pfn),
  .frame_dirty(frame_dirty),
  .frame_used (frame_used)
);

// File: tb/soft_tlb_bench.sv
module soft_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 4;
  localparam int VPN_W   = 20;
  localparam int PFN_W   = 5;
  localparam int FRAMES  = 1 << PFN_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [VPN_W-1:0] req_vpn = '0, cmd_vpn = '0;
  logic req_ready, rsp_valid;
  logic [1:0] rsp_cause;
  logic [PFN_W-1:0] rsp_pfn, cmd_pfn = '0;
  logic cmd_valid = 1'b0, cmd_writable = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [FRAMES-1:0] frame_dirty, frame_used;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [PFN_W+1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_soft_tlb (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_cause(rsp_cause), .rsp_pfn(rsp_pfn),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_vpn(cmd_vpn), .cmd_pfn(cmd_pfn),
    .cmd_writable(cmd_writable), .frame_dirty(frame_dirty), .frame_used(frame_used)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: pops the scoreboard when a response is consumed
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check("R10 unexpected response", 64'(rsp_valid), 64'd0);
        end else begin
          logic [PFN_W+1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, 64'({rsp_cause, rsp_pfn}), 64'(e));
        end
      end
    end
  end

  // driver: one lookup, optionally with a command landing at the same edge
  task automatic lookup(logic [VPN_W-1:0] vpn, logic wr, logic [1:0] cause,
                        logic [PFN_W-1:0] pfn, string tag, bit with_cmd = 1'b0);
    bit taken;
    @(posedge clk); #1;
    req_valid = 1'b1; req_vpn = vpn; req_write = wr;
    if (with_cmd) cmd_valid = 1'b1;
    taken = 1'b0;
    while (!taken) begin
      @(negedge clk);
      if (req_ready) begin
        exp_q.push_back({cause, pfn});
        tag_q.push_back(tag);
        taken = 1'b1;
      end
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
    cmd_valid = 1'b0;
  endtask

  task automatic set_cmd(logic [1:0] op, logic [VPN_W-1:0] vpn, logic [PFN_W-1:0] pfn, logic wr);
    cmd_op = op; cmd_vpn = vpn; cmd_pfn = pfn; cmd_writable = wr;
  endtask

  task automatic command(logic [1:0] op, logic [VPN_W-1:0] vpn, logic [PFN_W-1:0] pfn, logic wr);
    @(posedge clk); #1;
    set_cmd(op, vpn, pfn, wr);
    cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      check("R10 watchdog", 64'd0, 64'd1);
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 dirty", 64'(frame_dirty), 64'd0);
    check("R1 used", 64'(frame_used), 64'd0);
    lookup(20'h100, 1'b0, 2'b01, 0, "R1 empty read miss");
    // R2 write miss
    lookup(20'h100, 1'b1, 2'b01, 0, "R2 write miss");

    // R5 read-only fill
    command(2'b01, 20'h100, 5'd3, 1'b0);
    check("R5 used after fill", 64'(frame_used), 64'h8);
    check("R5 clean after ro fill", 64'(frame_dirty), 64'h0);
    lookup(20'h100, 1'b0, 2'b00, 5'd3, "R3 read hit ro");
    lookup(20'h100, 1'b1, 2'b10, 0, "R4 write to unmodified");

    // R6 upgrade
    command(2'b10, 20'h100, 5'd0, 1'b0);
    check("R6 dirty after upgrade", 64'(frame_dirty), 64'h8);
    lookup(20'h100, 1'b1, 2'b00, 5'd3, "R4 write hit modified");
    command(2'b10, 20'h999, 5'd0, 1'b0);
    check("R6 no-match upgrade dirty", 64'(frame_dirty), 64'h8);
    check("R6 no-match upgrade used", 64'(frame_used), 64'h8);
    command(2'b00, 20'h100, 5'd20, 1'b1);
    check("R7 code 00 does nothing", 64'(frame_used), 64'h8);

    // R5 writable fill
    command(2'b01, 20'h200, 5'd7, 1'b1);
    check("R5 dirty after rw fill", 64'(frame_dirty), 64'h88);
    lookup(20'h200, 1'b1, 2'b00, 5'd7, "R5 rw fill write hit");

    // R9 shared frame 3
    command(2'b01, 20'h300, 5'd3, 1'b0);
    lookup(20'h300, 1'b0, 2'b00, 5'd3, "R9 alias read");
    lookup(20'h300, 1'b1, 2'b10, 0, "R9 alias still traps");
    check("R9 frame 3 dirty via other mapping", 64'(frame_dirty[3]), 64'd1);

    // R7 invalidate
    command(2'b11, 20'h555, 5'd0, 1'b0);
    lookup(20'h200, 1'b0, 2'b00, 5'd7, "R7 no-match invalidate");
    command(2'b11, 20'h200, 5'd0, 1'b0);
    lookup(20'h200, 1'b0, 2'b01, 0, "R7 invalidated miss");
    check("R9 dirty sticky after invalidate", 64'(frame_dirty[7]), 64'd1);

    // R8 round robin: slots 0:100 1:(free) 2:300, pointer at 3
    command(2'b01, 20'h400, 5'd9, 1'b0);   // slot 3
    command(2'b01, 20'h500, 5'd10, 1'b0);  // slot 0, evicts 100
    lookup(20'h100, 1'b0, 2'b01, 0, "R8 wrap evicts slot 0");
    lookup(20'h300, 1'b0, 2'b00, 5'd3, "R8 slot 2 kept");
    command(2'b01, 20'h300, 5'd12, 1'b1);  // rewrite slot 2 in place
    lookup(20'h300, 1'b1, 2'b00, 5'd12, "R8 in-place rewrite");
    command(2'b01, 20'h600, 5'd13, 1'b0);  // slot 1
    command(2'b01, 20'h700, 5'd14, 1'b0);  // slot 2, evicts 300
    lookup(20'h300, 1'b0, 2'b01, 0, "R8 pointer not moved by rewrite");
    lookup(20'h400, 1'b0, 2'b00, 5'd9, "R8 slot 3 kept");
    lookup(20'h500, 1'b0, 2'b00, 5'd10, "R8 slot 0 kept");
    lookup(20'h600, 1'b0, 2'b00, 5'd13, "R8 slot 1 filled");

    // R10 same-cycle fill and lookup
    set_cmd(2'b01, 20'h800, 5'd15, 1'b1);
    lookup(20'h800, 1'b0, 2'b01, 0, "R10 same-cycle fill unseen", 1'b1);
    lookup(20'h800, 1'b0, 2'b00, 5'd15, "R10 fill seen next");
    command(2'b01, 20'h900, 5'd16, 1'b0);
    set_cmd(2'b10, 20'h900, 5'd0, 1'b0);
    lookup(20'h900, 1'b1, 2'b10, 0, "R10 same-cycle upgrade unseen", 1'b1);
    lookup(20'h900, 1'b1, 2'b00, 5'd16, "R10 upgrade seen next");

    // R11 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    lookup(20'hA00, 1'b0, 2'b01, 0, "R11 held miss");
    fork
      lookup(20'h900, 1'b0, 2'b00, 5'd16, "R11 queued after stall");
      begin
        @(negedge clk);
        check("R11 stalled req_ready", 64'(req_ready), 64'd0);
        check("R11 held cause", 64'(rsp_cause), 64'd1);
        repeat (2) @(negedge clk);
        check("R11 still valid", 64'(rsp_valid), 64'd1);
        check("R11 still cause", 64'(rsp_cause), 64'd1);
        @(posedge clk); #1 rsp_ready = 1'b1;
      end
    join
    repeat (4) @(posedge clk);
    check("R10 scoreboard drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    report();
  end
endmodule